// File: doc/BRIEF.md
# Hardware Event Trace Capture

This block watches a 32-line bus of debug observability signals and turns chosen low-to-high transitions into trace event requests. Each line first passes through a per-bit polarity flip, so a signal that is active low can be handled as active high. A registered copy of the flipped value then feeds a rising-edge detector. A per-line enable mask decides which detected edges become requests. Requests wait in a pending set and leave one at a time as a 5-bit line index on a valid/ready stream. The trace packet builder downstream consumes this stream.

A second path sends the same observability bus to a pad-facing output. One control pin can force that output to all zeros to save power. The event path taps the bus before this gate, so events keep arriving while the pads are held at zero. A single-cycle write strobe with a word address loads the polarity and enable registers.

Stream rules: `evt_valid` is high whenever at least one request is pending. A request transfers on a clock edge where both `evt_valid` and `evt_ready` are high. Once an index has been offered, it does not change and it is not withdrawn until it is accepted, even if a lower line becomes pending in the meantime. The sink may hold `evt_ready` low for any length of time. Pending requests are not lost during that time, but repeat edges on a line that is already pending merge into its existing request.

Top module: `hwevt_capture`

## Requirements
- R1: After reset, `evt_valid` is 0, and the polarity and enable registers are all zeros. With an all-zero enable mask, a rising input line produces no event.
- R2: A rising edge on an enabled line, seen after polarity, makes `evt_valid` high at the next clock edge, with `evt_idx` equal to that line's number.
- R3: A rising edge on a line whose enable bit is 0 produces no event.
- R4: Register word address 0 is the polarity register. When bit i is 1, line i is inverted before edge detection, so a high-to-low transition on `obs_in[i]` raises an event and a low-to-high transition does not.
- R5: Changing a polarity bit so that the flipped value of the line goes from 0 to 1 is itself a rising edge and raises an event for that line, if the line is enabled.
- R6: When several lines are pending, they are offered one per accepted transfer, lowest line number first. An accepted request is removed from the pending set.
- R7: While `evt_valid` is high and `evt_ready` is low, `evt_valid` stays high and `evt_idx` stays unchanged, even if a lower-numbered line becomes pending.
- R8: A further rising edge on a line that is already pending merges into the existing request, so only one event is issued for it.
- R9: `obs_out` equals `obs_in` when `obs_gate_en` is 1, and is all zeros when `obs_gate_en` is 0.
- R10: Event capture is not affected by `obs_gate_en`. A rising edge on an enabled line still raises an event while the output is gated to zero.
- R11: Register word address 1 is the enable mask. A write to any other word address changes neither the polarity register nor the enable register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| obs_in | input | 32 | Debug observability lines, synchronous to clk |
| obs_gate_en | input | 1 | 1 passes obs_in to obs_out; 0 forces obs_out to zero |
| obs_out | output | 32 | Gated copy of obs_in for the pads |
| cfg_wr | input | 1 | Single-cycle register write strobe |
| cfg_addr | input | 2 | Word address: 0 polarity, 1 enable mask |
| cfg_wdata | input | 32 | Register write data |
| evt_valid | output | 1 | An event request is offered |
| evt_ready | input | 1 | Sink accepts the offered request |
| evt_idx | output | 5 | Line number of the offered request |

## Verification
A corrupted previous-sample register or polarity register shows up within one clock edge, either as an extra event or as a missing event on the stream. Mistakes in the pending set or the priority pick show up as a wrong `evt_idx`, a duplicated index, or a dropped index in the drain order after a multi-line burst. A broken hold under back-pressure shows up as `evt_idx` changing during a stall cycle. A fault in the gate is visible at `obs_out` combinationally, in the same cycle as the input change.

// File: rtl/hwevt_pkg.sv
package hwevt_pkg;
  localparam int HWEVT_ADDR_POL = 0;
  localparam int HWEVT_ADDR_EN  = 1;
endpackage

// File: rtl/hwevt_cfg_regs.sv
module hwevt_cfg_regs #(
  parameter int NUM_LINES = 32,
  parameter int ADDR_W    = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_wr,
  input  logic [ADDR_W-1:0]    cfg_addr,
  input  logic [NUM_LINES-1:0] cfg_wdata,
  output logic [NUM_LINES-1:0] pol_q,
  output logic [NUM_LINES-1:0] en_q
);
  import hwevt_pkg::*;

  logic hit_pol, hit_en;
  assign hit_pol = cfg_wr && (cfg_addr == ADDR_W'(HWEVT_ADDR_POL));
  assign hit_en  = cfg_wr && (cfg_addr == ADDR_W'(HWEVT_ADDR_EN));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pol_q <= '0;
      en_q  <= '0;
    end else begin
      if (hit_pol) pol_q <= cfg_wdata;
      if (hit_en)  en_q  <= cfg_wdata;
    end
  end

  AST_UNMAPPED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_addr != ADDR_W'(HWEVT_ADDR_POL) && cfg_addr != ADDR_W'(HWEVT_ADDR_EN))
    |=> ($stable(pol_q) && $stable(en_q))); // R11
endmodule

// File: rtl/hwevt_edge.sv
module hwevt_edge #(
  parameter int NUM_LINES = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] lines,
  input  logic [NUM_LINES-1:0] pol,
  input  logic [NUM_LINES-1:0] en,
  output logic [NUM_LINES-1:0] req
);
  logic [NUM_LINES-1:0] flip;
  logic [NUM_LINES-1:0] prev_q;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    assign flip[i] = lines[i] ^ pol[i];
    always_ff @(posedge clk) begin
      if (!rst_n) prev_q[i] <= 1'b0;
      else        prev_q[i] <= flip[i];
    end
    assign req[i] = flip[i] & ~prev_q[i] & en[i];
  end

  AST_REQ_NEEDS_LOW_PREV: assert property (@(posedge clk) disable iff (!rst_n)
    ((req & $past(flip)) == '0)); // R2
endmodule

// File: rtl/hwevt_arb.sv
module hwevt_arb #(
  parameter int NUM_LINES = 32,
  localparam int IDX_W    = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] req,
  output logic                 evt_valid,
  input  logic                 evt_ready,
  output logic [IDX_W-1:0]     evt_idx
);
  logic [NUM_LINES-1:0] pend_q, clr_mask;
  logic                 held_q;
  logic [IDX_W-1:0]     held_idx_q, pick;
  logic                 grant;

  always_comb begin
    pick = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (pend_q[i]) pick = IDX_W'(i);
    end
  end

  assign evt_valid = |pend_q;
  assign evt_idx   = held_q ? held_idx_q : pick;
  assign grant     = evt_valid && evt_ready;
  assign clr_mask  = grant ? ({{(NUM_LINES-1){1'b0}}, 1'b1} << evt_idx) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q     <= '0;
      held_q     <= 1'b0;
      held_idx_q <= '0;
    end else begin
      pend_q <= (pend_q & ~clr_mask) | req;
      if (grant) begin
        held_q <= 1'b0;
      end else if (evt_valid) begin
        held_q     <= 1'b1;
        held_idx_q <= evt_idx;
      end
    end
  end

  AST_IDX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && !evt_ready) |=> (evt_valid && evt_idx == $past(evt_idx))); // R7
  AST_IDX_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> pend_q[evt_idx]); // R6
  AST_ONE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones($past(pend_q) & ~pend_q) <= 1)); // R6
  AST_NEW_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & ~$past(pend_q) & ~$past(req)) == '0)); // R3
endmodule

// File: rtl/hwevt_capture.sv
module hwevt_capture #(
  parameter int NUM_LINES = 32,
  parameter int ADDR_W    = 2,
  localparam int IDX_W    = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] obs_in,
  input  logic                 obs_gate_en,
  output logic [NUM_LINES-1:0] obs_out,
  input  logic                 cfg_wr,
  input  logic [ADDR_W-1:0]    cfg_addr,
  input  logic [NUM_LINES-1:0] cfg_wdata,
  output logic                 evt_valid,
  input  logic                 evt_ready,
  output logic [IDX_W-1:0]     evt_idx
);
  logic [NUM_LINES-1:0] pol, en, req;

  assign obs_out = obs_gate_en ? obs_in : '0;

  hwevt_cfg_regs #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .pol_q(pol), .en_q(en)
  );

  hwevt_edge #(.NUM_LINES(NUM_LINES)) u_edge (
    .clk(clk), .rst_n(rst_n), .lines(obs_in), .pol(pol), .en(en), .req(req)
  );

  hwevt_arb #(.NUM_LINES(NUM_LINES)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(req), .evt_valid(evt_valid),
    .evt_ready(evt_ready), .evt_idx(evt_idx)
  );

  AST_REQ_ENABLED_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    ((req & ~en) == '0)); // R3
endmodule

// File: tb/test_hwevt_capture.sv
module test_hwevt_capture;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] obs_in = '0;
  logic        obs_gate_en = 1'b1;
  logic [31:0] obs_out;
  logic        cfg_wr = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        evt_valid;
  logic        evt_ready = 1'b0;
  logic [4:0]  evt_idx;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  hwevt_capture i_hwevt_capture (
    .clk(clk), .rst_n(rst_n), .obs_in(obs_in), .obs_gate_en(obs_gate_en),
    .obs_out(obs_out), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .evt_valid(evt_valid), .evt_ready(evt_ready),
    .evt_idx(evt_idx)
  );

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_reg(logic [1:0] a, logic [31:0] d);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    step();
    cfg_wr = 1'b0;
  endtask

  task automatic accept_one();
    evt_ready = 1'b1;
    step();
    evt_ready = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 valid", 32'(evt_valid), 32'd0);
    obs_in[3] = 1'b1;
    step(2);
    check("R1 no event with zero mask", 32'(evt_valid), 32'd0);
    obs_in[3] = 1'b0;
    step();
  endtask

  task automatic t_single();
    wr_reg(2'd1, 32'hFFFF_FFFF);
    obs_in[5] = 1'b1;
    step();
    check("R2 valid", 32'(evt_valid), 32'd1);
    check("R2 idx", 32'(evt_idx), 32'd5);
    accept_one();
    check("R2 drained", 32'(evt_valid), 32'd0);
    obs_in[5] = 1'b0;
    step();
  endtask

  task automatic t_disabled();
    wr_reg(2'd1, ~(32'd1 << 7));
    obs_in[7] = 1'b1;
    step(2);
    check("R3 disabled line", 32'(evt_valid), 32'd0);
    obs_in[7] = 1'b0;
    step();
    wr_reg(2'd1, 32'hFFFF_FFFF);
    step();
  endtask

  task automatic t_polarity();
    wr_reg(2'd0, 32'd1 << 9);
    step();
    check("R5 polarity change valid", 32'(evt_valid), 32'd1);
    check("R5 polarity change idx", 32'(evt_idx), 32'd9);
    accept_one();
    obs_in[9] = 1'b1;
    step(2);
    check("R4 inverted rise ignored", 32'(evt_valid), 32'd0);
    obs_in[9] = 1'b0;
    step();
    check("R4 inverted fall valid", 32'(evt_valid), 32'd1);
    check("R4 inverted fall idx", 32'(evt_idx), 32'd9);
    accept_one();
    wr_reg(2'd0, 32'd0);
    step();
    check("R4 polarity restore no event", 32'(evt_valid), 32'd0);
  endtask

  task automatic t_multi();
    obs_in = (32'd1 << 2) | (32'd1 << 12) | (32'd1 << 30);
    step();
    check("R6 first idx", 32'(evt_idx), 32'd2);
    step();
    check("R7 stall valid", 32'(evt_valid), 32'd1);
    check("R7 stall idx", 32'(evt_idx), 32'd2);
    obs_in[0] = 1'b1;
    step();
    check("R7 held against lower line", 32'(evt_idx), 32'd2);
    evt_ready = 1'b1;
    step();
    check("R6 next lowest", 32'(evt_idx), 32'd0);
    step();
    check("R6 third", 32'(evt_idx), 32'd12);
    step();
    check("R6 fourth", 32'(evt_idx), 32'd30);
    step();
    check("R6 empty", 32'(evt_valid), 32'd0);
    evt_ready = 1'b0;
    obs_in = '0;
    step();
  endtask

  task automatic t_merge();
    obs_in[4] = 1'b1;
    step();
    obs_in[4] = 1'b0;
    step();
    obs_in[4] = 1'b1;
    step();
    check("R8 pending idx", 32'(evt_idx), 32'd4);
    accept_one();
    check("R8 merged single event", 32'(evt_valid), 32'd0);
    obs_in = '0;
    step();
  endtask

  task automatic t_gate();
    obs_gate_en = 1'b0;
    obs_in[8] = 1'b1;
    step();
    check("R9 gated output", obs_out, 32'd0);
    check("R10 event while gated valid", 32'(evt_valid), 32'd1);
    check("R10 event while gated idx", 32'(evt_idx), 32'd8);
    obs_gate_en = 1'b1;
    #1;
    check("R9 open output", obs_out, 32'h0000_0100);
    accept_one();
    obs_in = '0;
    step();
  endtask

  task automatic t_unmapped();
    wr_reg(2'd1, 32'd0);
    wr_reg(2'd2, 32'hFFFF_FFFF);
    wr_reg(2'd3, 32'hFFFF_FFFF);
    step();
    check("R11 polarity untouched", 32'(evt_valid), 32'd0);
    obs_in[1] = 1'b1;
    step(2);
    check("R11 enable untouched", 32'(evt_valid), 32'd0);
    obs_in = '0;
    step();
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step();
    t_reset();
    t_single();
    t_disabled();
    t_polarity();
    t_multi();
    t_merge();
    t_gate();
    t_unmapped();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule